// File: doc/BRIEF.md
# Next Program Address Unit

This block keeps the 32-bit program counter of a simple word-aligned processor and works out its successor once per completed instruction. A decoder elsewhere supplies one-hot-style control flags (branch on equal, branch on not-equal, region jump, jump with link, jump through register), the low immediate bits of the current instruction, an equality flag for the two register operands and a register value for indirect jumps. The unit computes every candidate target in parallel and picks one by a fixed priority.

When the instruction-complete strobe is high, the chosen address is loaded on the rising clock edge. In the same cycle, a jump with link raises a write enable toward the return-address register (index 31) and offers the address of the following instruction as write data. This lets the register file capture the link on the same edge. A flag marks any program counter value whose two low bits are not zero.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_o` becomes `START_ADDR` (default 0x0040_0000) and `link_we_o` is 0 as long as `step_i` is 0.
- R2: With `step_i` low, `pc_o` keeps its value whatever the control inputs are, and `link_we_o` stays 0.
- R3: On a step with no transfer selected, including a branch whose condition fails, `pc_o` becomes `pc_o + 4`.
- R4: On a step with `ctl_beq_i` set and `ops_equal_i` high, `pc_o` becomes `pc_o + 4 + (sign-extended imm_field_i[15:0] * 4)`; with `ops_equal_i` low it advances by 4.
- R5: On a step with `ctl_bne_i` set and `ops_equal_i` low, `pc_o` takes the same PC-relative target as R4; with `ops_equal_i` high it advances by 4.
- R6: On a step with `ctl_jmp_i` or `ctl_jal_i` set, `pc_o` becomes `{(pc_o+4)[31:28], imm_field_i[25:0], 2'b00}`; the four region bits come from the incremented address.
- R7: `link_we_o` is high exactly when `step_i` and `ctl_jal_i` are high and `ctl_jr_i` is low; meanwhile `link_data_o` equals `pc_o + 4` and `link_idx_o` equals 31.
- R8: On a step with `ctl_jr_i` set, `pc_o` becomes `reg_tgt_i`.
- R9: When several controls are set, register jump wins over region jumps, which win over branches, which win over sequential flow.
- R10: `misalign_o` is 1 exactly when `pc_o[1:0]` is not zero.
- R11: Address arithmetic wraps modulo 2^32; stepping from 0xFFFF_FFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Instruction-complete strobe; enables the update |
| imm_field_i | input | 26 | Low 26 instruction bits; bits 15:0 are the branch offset |
| ops_equal_i | input | 1 | High when the two register operands are equal |
| reg_tgt_i | input | 32 | Register value for the indirect jump |
| ctl_beq_i | input | 1 | Branch on equal |
| ctl_bne_i | input | 1 | Branch on not-equal |
| ctl_jmp_i | input | 1 | Region jump |
| ctl_jal_i | input | 1 | Region jump with link |
| ctl_jr_i | input | 1 | Jump through register |
| pc_o | output | 32 | Current program counter |
| link_data_o | output | 32 | Return address (`pc_o + 4`) |
| link_we_o | output | 1 | Write enable for the return-address register |
| link_idx_o | output | 5 | Index of the return-address register (31) |
| misalign_o | output | 1 | Low two PC bits are non-zero |

## Verification
The checker watches every cycle for these properties:
- the reset value on release;
- the hold while the strobe is low;
- the +4 advance when no transfer is selected;
- the register-jump load;
- the low 28 bits of a region jump;
- the link enable and link data;
- the preservation of alignment on every path other than the register jump.

Only the bench scenarios can show the following:
- the branch arithmetic with positive and negative offsets;
- the region bits taken across a 256 MiB boundary;
- the wrap at the top of the address space;
- the full priority order when several controls are set together.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

   typedef enum logic [1:0] {
      SEL_SEQ    = 2'd0,
      SEL_BRANCH = 2'd1,
      SEL_REGION = 2'd2,
      SEL_REG    = 2'd3
   } nxt_sel_e;

endpackage

// File: rtl/pc_target_calc.sv
module pc_target_calc #(
   parameter int ADDR_W = 32,
   parameter int TGT_W  = 26,
   parameter int OFF_W  = 16
) (
   input  logic [ADDR_W-1:0] pc_i,
   input  logic [TGT_W-1:0]  field_i,
   output logic [ADDR_W-1:0] seq_o,
   output logic [ADDR_W-1:0] br_o,
   output logic [ADDR_W-1:0] region_o
);
   localparam int WSH   = 2;
   localparam int REG_W = ADDR_W - TGT_W - WSH;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << WSH);

   logic [ADDR_W-1:0] off_ext;

   assign off_ext  = {{(ADDR_W-OFF_W){field_i[OFF_W-1]}}, field_i[OFF_W-1:0]};
   assign seq_o    = pc_i + STEP;
   assign br_o     = seq_o + (off_ext << WSH);
   assign region_o = {seq_o[ADDR_W-1 -: REG_W], field_i, {WSH{1'b0}}};

endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
   import pc_seq_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              jr_i,
   input  logic              jmp_i,
   input  logic              jal_i,
   input  logic              beq_i,
   input  logic              bne_i,
   input  logic              eq_i,
   input  logic [ADDR_W-1:0] seq_i,
   input  logic [ADDR_W-1:0] br_i,
   input  logic [ADDR_W-1:0] region_i,
   input  logic [ADDR_W-1:0] reg_i,
   output nxt_sel_e          sel_o,
   output logic [ADDR_W-1:0] next_o,
   output logic              link_take_o
);
   logic br_taken;

   assign br_taken = (beq_i & eq_i) | (bne_i & ~eq_i);

   always_comb begin
      if (jr_i)                sel_o = SEL_REG;
      else if (jmp_i | jal_i)  sel_o = SEL_REGION;
      else if (br_taken)       sel_o = SEL_BRANCH;
      else                     sel_o = SEL_SEQ;
   end

   always_comb begin
      case (sel_o)
         SEL_REG:    next_o = reg_i;
         SEL_REGION: next_o = region_i;
         SEL_BRANCH: next_o = br_i;
         default:    next_o = seq_i;
      endcase
   end

   assign link_take_o = jal_i & ~jr_i;

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
   import pc_seq_pkg::*;
#(
   parameter int                ADDR_W        = 32,
   parameter int                TGT_W         = 26,
   parameter int                OFF_W         = 16,
   parameter int                IDX_W         = 5,
   parameter int                LINK_IDX      = 31,
   parameter logic [ADDR_W-1:0] START_ADDR    = 32'h0040_0000,
   parameter bit                ALIGN_FLAG_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_i,
   input  logic [TGT_W-1:0]  imm_field_i,
   input  logic              ops_equal_i,
   input  logic [ADDR_W-1:0] reg_tgt_i,
   input  logic              ctl_beq_i,
   input  logic              ctl_bne_i,
   input  logic              ctl_jmp_i,
   input  logic              ctl_jal_i,
   input  logic              ctl_jr_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic [ADDR_W-1:0] link_data_o,
   output logic              link_we_o,
   output logic [IDX_W-1:0]  link_idx_o,
   output logic              misalign_o
);
   localparam int REG_W = ADDR_W - TGT_W - 2;
   localparam logic [IDX_W-1:0] LINK_SEL = IDX_W'(LINK_IDX);

   if (REG_W < 1) begin : g_bad_tgt
      $error("pc_sequencer: TGT_W leaves no region bits");
   end
   if (OFF_W > TGT_W) begin : g_bad_off
      $error("pc_sequencer: OFF_W must not exceed TGT_W");
   end
   if (START_ADDR[1:0] != 2'b00) begin : g_bad_start
      $error("pc_sequencer: START_ADDR must be word aligned");
   end
   if (LINK_IDX >= (1 << IDX_W)) begin : g_bad_idx
      $error("pc_sequencer: LINK_IDX does not fit IDX_W");
   end

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] seq_addr;
   logic [ADDR_W-1:0] br_addr;
   logic [ADDR_W-1:0] region_addr;
   logic [ADDR_W-1:0] next_addr;
   logic              link_take;
   nxt_sel_e          sel;

   pc_target_calc #(
      .ADDR_W (ADDR_W),
      .TGT_W  (TGT_W),
      .OFF_W  (OFF_W)
   ) u_calc (
      .pc_i     (pc_q),
      .field_i  (imm_field_i),
      .seq_o    (seq_addr),
      .br_o     (br_addr),
      .region_o (region_addr)
   );

   pc_next_sel #(
      .ADDR_W (ADDR_W)
   ) u_sel (
      .jr_i        (ctl_jr_i),
      .jmp_i       (ctl_jmp_i),
      .jal_i       (ctl_jal_i),
      .beq_i       (ctl_beq_i),
      .bne_i       (ctl_bne_i),
      .eq_i        (ops_equal_i),
      .seq_i       (seq_addr),
      .br_i        (br_addr),
      .region_i    (region_addr),
      .reg_i       (reg_tgt_i),
      .sel_o       (sel),
      .next_o      (next_addr),
      .link_take_o (link_take)
   );

   always_ff @(posedge clk) begin
      if (rst)          pc_q <= START_ADDR;
      else if (step_i)  pc_q <= next_addr;
   end

   assign pc_o        = pc_q;
   assign link_data_o = seq_addr;
   assign link_we_o   = step_i & link_take;
   assign link_idx_o  = LINK_SEL;

   if (ALIGN_FLAG_EN) begin : g_align_flag
      assign misalign_o = |pc_q[1:0];
   end else begin : g_no_align_flag
      assign misalign_o = 1'b0;
   end

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
   parameter int                ADDR_W     = 32,
   parameter int                TGT_W      = 26,
   parameter int                IDX_W      = 5,
   parameter int                LINK_IDX   = 31,
   parameter logic [ADDR_W-1:0] START_ADDR = 32'h0040_0000
) (
   input logic              clk,
   input logic              rst,
   input logic              step_i,
   input logic [TGT_W-1:0]  imm_field_i,
   input logic              ops_equal_i,
   input logic [ADDR_W-1:0] reg_tgt_i,
   input logic              ctl_beq_i,
   input logic              ctl_bne_i,
   input logic              ctl_jmp_i,
   input logic              ctl_jal_i,
   input logic              ctl_jr_i,
   input logic [ADDR_W-1:0] pc_o,
   input logic [ADDR_W-1:0] link_data_o,
   input logic              link_we_o,
   input logic [IDX_W-1:0]  link_idx_o,
   input logic              misalign_o
);
   localparam logic [ADDR_W-1:0] FOUR = ADDR_W'(4);

   logic no_xfer;
   assign no_xfer = !ctl_jr_i && !ctl_jmp_i && !ctl_jal_i
                    && !(ctl_beq_i && ops_equal_i) && !(ctl_bne_i && !ops_equal_i);

   p_reset_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (pc_o == START_ADDR));

   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(pc_o));

   p_seq_r3: assert property (@(posedge clk) disable iff (rst)
      (step_i && no_xfer) |=> (pc_o == $past(pc_o) + FOUR));

   p_region_r6: assert property (@(posedge clk) disable iff (rst)
      (step_i && !ctl_jr_i && (ctl_jmp_i || ctl_jal_i))
      |=> (pc_o[TGT_W+1:0] == {$past(imm_field_i), 2'b00}));

   p_link_r7: assert property (@(posedge clk) disable iff (rst)
      link_we_o |-> (step_i && ctl_jal_i && link_data_o == pc_o + FOUR
                     && link_idx_o == IDX_W'(LINK_IDX)));

   p_nolink_r7: assert property (@(posedge clk) disable iff (rst)
      (!step_i || !ctl_jal_i || ctl_jr_i) |-> !link_we_o);

   p_jr_r8: assert property (@(posedge clk) disable iff (rst)
      (step_i && ctl_jr_i) |=> (pc_o == $past(reg_tgt_i)));

   p_align_keep_r10: assert property (@(posedge clk) disable iff (rst)
      (step_i && !ctl_jr_i && !misalign_o) |=> !misalign_o);

endmodule

bind pc_sequencer pc_sequencer_chk #(
   .ADDR_W     (ADDR_W),
   .TGT_W      (TGT_W),
   .IDX_W      (IDX_W),
   .LINK_IDX   (LINK_IDX),
   .START_ADDR (START_ADDR)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .step_i      (step_i),
   .imm_field_i (imm_field_i),
   .ops_equal_i (ops_equal_i),
   .reg_tgt_i   (reg_tgt_i),
   .ctl_beq_i   (ctl_beq_i),
   .ctl_bne_i   (ctl_bne_i),
   .ctl_jmp_i   (ctl_jmp_i),
   .ctl_jal_i   (ctl_jal_i),
   .ctl_jr_i    (ctl_jr_i),
   .pc_o        (pc_o),
   .link_data_o (link_data_o),
   .link_we_o   (link_we_o),
   .link_idx_o  (link_idx_o),
   .misalign_o  (misalign_o)
);

// File: tb/pc_sequencer_bench.sv
module pc_sequencer_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] START = 32'h0040_0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        step_i = 1'b0;
   logic [25:0] imm_field_i = '0;
   logic        ops_equal_i = 1'b0;
   logic [31:0] reg_tgt_i = '0;
   logic        ctl_beq_i = 1'b0, ctl_bne_i = 1'b0, ctl_jmp_i = 1'b0;
   logic        ctl_jal_i = 1'b0, ctl_jr_i = 1'b0;
   logic [31:0] pc_o, link_data_o;
   logic        link_we_o, misalign_o;
   logic [4:0]  link_idx_o;

   int n_checks = 0;
   int n_fail   = 0;
   logic [31:0] exp_pc;

   always #(CLK_PERIOD/2) clk = ~clk;

   pc_sequencer u_pc_sequencer (
      .clk(clk), .rst(rst), .step_i(step_i), .imm_field_i(imm_field_i),
      .ops_equal_i(ops_equal_i), .reg_tgt_i(reg_tgt_i),
      .ctl_beq_i(ctl_beq_i), .ctl_bne_i(ctl_bne_i), .ctl_jmp_i(ctl_jmp_i),
      .ctl_jal_i(ctl_jal_i), .ctl_jr_i(ctl_jr_i), .pc_o(pc_o),
      .link_data_o(link_data_o), .link_we_o(link_we_o),
      .link_idx_o(link_idx_o), .misalign_o(misalign_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] f_rel(input logic [31:0] pc, input logic [15:0] off);
      return pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
   endfunction

   function automatic logic [31:0] f_region(input logic [31:0] pc, input logic [25:0] t);
      logic [31:0] nx;
      nx = pc + 32'd4;
      return {nx[31:28], t, 2'b00};
   endfunction

   task automatic clear_ctl();
      ctl_beq_i = 0; ctl_bne_i = 0; ctl_jmp_i = 0; ctl_jal_i = 0; ctl_jr_i = 0;
      ops_equal_i = 0; imm_field_i = '0; reg_tgt_i = '0;
   endtask

   // Drives controls at the falling edge, strobes one rising edge, samples after it.
   task automatic do_step(input logic beq, input logic bne, input logic jmp, input logic jal,
                          input logic jr, input logic eq, input logic [25:0] fld,
                          input logic [31:0] rtgt);
      @(negedge clk);
      ctl_beq_i = beq; ctl_bne_i = bne; ctl_jmp_i = jmp; ctl_jal_i = jal;
      ctl_jr_i = jr; ops_equal_i = eq; imm_field_i = fld; reg_tgt_i = rtgt;
      step_i = 1'b1;
      @(posedge clk); #1;
      step_i = 1'b0;
      clear_ctl();
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      chk("R1 pc after reset", pc_o, START);
      chk("R1 link_we in reset", {31'd0, link_we_o}, 32'd0);
      @(negedge clk); rst = 1'b0;
      exp_pc = START;
   endtask

   task automatic t_hold();
      @(negedge clk);
      ctl_jr_i = 1; ctl_jal_i = 1; reg_tgt_i = 32'h1234_5670; step_i = 0;
      #1;
      chk("R2 link_we with strobe low", {31'd0, link_we_o}, 32'd0);
      repeat (3) @(posedge clk);
      #1;
      chk("R2 pc held", pc_o, exp_pc);
      clear_ctl();
   endtask

   task automatic t_seq();
      for (int i = 0; i < 3; i++) begin
         do_step(0, 0, 0, 0, 0, 0, 26'h3FF_FFFF, 32'hDEAD_BEE0);
         exp_pc = exp_pc + 32'd4;
         chk("R3 sequential +4", pc_o, exp_pc);
      end
   endtask

   task automatic t_beq();
      do_step(1, 0, 0, 0, 0, 1, 26'h0000003, 0);
      exp_pc = f_rel(exp_pc, 16'h0003);
      chk("R4 beq taken positive", pc_o, exp_pc);
      do_step(1, 0, 0, 0, 0, 1, 26'h000FFFE, 0);
      exp_pc = f_rel(exp_pc, 16'hFFFE);
      chk("R4 beq taken negative", pc_o, exp_pc);
      do_step(1, 0, 0, 0, 0, 0, 26'h0000040, 0);
      exp_pc = exp_pc + 32'd4;
      chk("R4 R3 beq not taken", pc_o, exp_pc);
   endtask

   task automatic t_bne();
      do_step(0, 1, 0, 0, 0, 0, 26'h0000005, 0);
      exp_pc = f_rel(exp_pc, 16'h0005);
      chk("R5 bne taken", pc_o, exp_pc);
      do_step(0, 1, 0, 0, 0, 1, 26'h0000005, 0);
      exp_pc = exp_pc + 32'd4;
      chk("R5 bne not taken", pc_o, exp_pc);
   endtask

   task automatic t_jump();
      do_step(0, 0, 1, 0, 0, 0, 26'h0123456, 0);
      exp_pc = f_region(exp_pc, 26'h0123456);
      chk("R6 region jump", pc_o, exp_pc);
   endtask

   task automatic t_jal();
      @(negedge clk);
      ctl_jal_i = 1; imm_field_i = 26'h0100040; step_i = 1;
      #1;
      chk("R7 link_we", {31'd0, link_we_o}, 32'd1);
      chk("R7 link data", link_data_o, exp_pc + 32'd4);
      chk("R7 link index", {27'd0, link_idx_o}, 32'd31);
      @(posedge clk); #1;
      step_i = 0; clear_ctl();
      exp_pc = f_region(exp_pc, 26'h0100040);
      chk("R6 R7 jal target", pc_o, exp_pc);
      #1;
      chk("R7 link_we drops", {31'd0, link_we_o}, 32'd0);
   endtask

   task automatic t_jr_edges();
      do_step(0, 0, 0, 0, 1, 0, 0, 32'h0FFF_FFFC);
      exp_pc = 32'h0FFF_FFFC;
      chk("R8 register jump", pc_o, exp_pc);
      do_step(0, 0, 1, 0, 0, 0, 26'h0000010, 0);
      chk("R6 region bits from pc+4", pc_o, 32'h1000_0040);
      exp_pc = 32'h1000_0040;
      do_step(0, 0, 0, 0, 1, 0, 0, 32'hFFFF_FFFC);
      exp_pc = 32'hFFFF_FFFC;
      chk("R8 register jump top", pc_o, exp_pc);
      do_step(0, 0, 0, 0, 0, 0, 0, 0);
      exp_pc = 32'h0000_0000;
      chk("R11 wrap to zero", pc_o, exp_pc);
   endtask

   task automatic t_prio();
      do_step(1, 0, 1, 0, 1, 1, 26'h0000100, 32'h0000_8000);
      exp_pc = 32'h0000_8000;
      chk("R9 jr beats jump and branch", pc_o, exp_pc);
      do_step(1, 0, 1, 0, 0, 1, 26'h0000200, 0);
      exp_pc = f_region(exp_pc, 26'h0000200);
      chk("R9 jump beats branch", pc_o, exp_pc);
      do_step(0, 1, 0, 0, 0, 0, 26'h0000002, 0);
      exp_pc = f_rel(exp_pc, 16'h0002);
      chk("R9 branch beats sequential", pc_o, exp_pc);
      @(negedge clk);
      ctl_jal_i = 1; ctl_jr_i = 1; reg_tgt_i = 32'h0000_9000; step_i = 1;
      #1;
      chk("R9 R7 no link when jr wins", {31'd0, link_we_o}, 32'd0);
      @(posedge clk); #1;
      step_i = 0; clear_ctl();
      exp_pc = 32'h0000_9000;
      chk("R9 jr beats jal", pc_o, exp_pc);
   endtask

   task automatic t_misalign();
      chk("R10 aligned flag low", {31'd0, misalign_o}, 32'd0);
      do_step(0, 0, 0, 0, 1, 0, 0, 32'h0040_0002);
      chk("R10 misalign flag high", {31'd0, misalign_o}, 32'd1);
      chk("R8 misaligned load", pc_o, 32'h0040_0002);
      do_step(0, 0, 0, 0, 1, 0, 0, 32'h0040_0100);
      chk("R10 flag clears", {31'd0, misalign_o}, 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_hold();
      t_seq();
      t_beq();
      t_bne();
      t_jump();
      t_jal();
      t_jr_edges();
      t_prio();
      t_misalign();
      t_reset();
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule